// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register storage of a 32-bit processor that runs in several privilege modes. Sixteen logical register numbers are visible to the instruction stream. Depending on the current mode, some of those numbers resolve to private physical copies: every exception mode keeps its own stack pointer and return-address register. The fast-interrupt mode also keeps its own copies of registers 8 to 12. Because of that larger bank, its handler can use those registers at once without spilling them first.

The block has two combinational read ports and one write port that takes effect on the clock edge. All three are addressed by a 4-bit logical number and resolved through the 5-bit mode input. Logical number 15 is the program counter. It reads back the `pc_in` input and is never stored here. A separate saved-status port reads and writes the status copy that belongs to the current exception mode.

Top module: `mbreg_file`

## Requirements
- R1: A synchronous active-high reset clears every physical register and every saved-status copy to zero, so after reset all numbers 0 to 14 read zero in every mode.
- R2: A write with `wr_en` high to number 0..14 is visible on both read ports from the cycle after the clock edge. The two read ports are combinational and independent.
- R3: When a read and a write address the same physical register in the same cycle, the read returns the value held before the edge.
- R4: Reading number 15 returns `pc_in` on either port. A write to number 15 changes no register in any mode.
- R5: Numbers 0 to 7 are one shared set seen by every mode.
- R6: Numbers 8 to 12 are shared by all modes except fast interrupt, which has its own private set of five.
- R7: Numbers 13 and 14 have a private pair in each of fast interrupt, interrupt, supervisor, abort and undefined. User and system modes share one pair.
- R8: Each of the five exception modes has its own saved-status register. `ss_wr_en` writes the copy of the current mode on the clock edge, and `ss_rd_data` shows the current mode's copy.
- R9: In user and system mode, `ss_rd_data` reads zero and `ss_wr_en` changes no saved-status copy.
- R10: Mode encodings are user 5'b10000, fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011 and system 5'b11111. Any other value behaves as user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current operating mode |
| pc_in | input | 32 | Program counter value returned for number 15 |
| ra_idx | input | 4 | Read port A logical number |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B logical number |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical number |
| wr_data | input | 32 | Write data |
| ss_wr_en | input | 1 | Saved-status write enable |
| ss_wr_data | input | 32 | Saved-status write data |
| ss_rd_data | output | 32 | Saved-status read data for the current mode |

## Verification
Aliasing is the hardest thing to expose from the ports. A write in one mode must land in exactly the physical copies that the other six modes share. Every logical number must stay clear of every bank that it does not share with the writing mode. The stimulus writes a unique value to every number in every mode, one at a time. After each write it reads all sixteen numbers in all seven modes, so every leak or missing share between two modes shows up as a mismatch. Same-cycle read-during-write is reached by holding the read index on the write target and sampling just before the edge.

// File: rtl/mbreg_pkg.sv
package mbreg_pkg;

    localparam int DATA_W   = 32;
    localparam int IDX_W    = 4;
    localparam int MODE_W   = 5;
    localparam int NUM_LOG  = 1 << IDX_W;
    localparam int PC_IDX   = NUM_LOG - 1;
    localparam int LOW_N    = 8;
    localparam int HI_N     = 5;
    localparam int NUM_GRP  = 6;
    localparam int USR_HI_BASE = LOW_N;
    localparam int FIQ_HI_BASE = USR_HI_BASE + HI_N;
    localparam int SPLR_BASE   = FIQ_HI_BASE + HI_N;
    localparam int PHYS_N      = SPLR_BASE + 2 * NUM_GRP;
    localparam int PHYS_W      = $clog2(PHYS_N);
    localparam int NUM_SS      = NUM_GRP - 1;
    localparam int SS_W        = $clog2(NUM_SS);

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        G_USR = 3'd0,
        G_FIQ = 3'd1,
        G_IRQ = 3'd2,
        G_SVC = 3'd3,
        G_ABT = 3'd4,
        G_UND = 3'd5
    } grp_e;

    typedef struct packed {
        logic [PHYS_W-1:0] phys;
        logic              is_pc;
    } map_t;

    function automatic grp_e mode_group(input logic [MODE_W-1:0] m);
        grp_e g;
        case (m)
            M_FIQ:   g = G_FIQ;
            M_IRQ:   g = G_IRQ;
            M_SVC:   g = G_SVC;
            M_ABT:   g = G_ABT;
            M_UND:   g = G_UND;
            default: g = G_USR;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/mbreg_map.sv
module mbreg_map
    import mbreg_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [MODE_W-1:0] mode,
    output map_t              map
);
    grp_e grp;
    int   sel;

    always_comb begin
        grp = mode_group(mode);
        sel = 0;
        if (int'(idx) < LOW_N)
            sel = int'(idx);
        else if (int'(idx) < LOW_N + HI_N)
            sel = ((grp == G_FIQ) ? FIQ_HI_BASE : USR_HI_BASE) + int'(idx) - LOW_N;
        else if (int'(idx) != PC_IDX)
            sel = SPLR_BASE + 2 * int'(grp) + int'(idx) - (LOW_N + HI_N);
        map.phys  = PHYS_W'(sel);
        map.is_pc = (int'(idx) == PC_IDX);
    end

    always_comb begin
        if (!map.is_pc) begin
            a_r7_phys_in_range: assert (int'(map.phys) < PHYS_N);
        end
        if (int'(idx) < LOW_N) begin
            a_r5_low_unbanked: assert (int'(map.phys) == int'(idx));
        end
    end

endmodule

// File: rtl/mbreg_ss_bank.sv
module mbreg_ss_bank
    import mbreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] ss_q [NUM_SS];
    grp_e              grp;
    logic              has_ss;
    logic [SS_W-1:0]   slot;

    always_comb begin
        grp    = mode_group(mode);
        has_ss = (grp != G_USR);
        slot   = has_ss ? SS_W'(int'(grp) - 1) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SS; i++) ss_q[i] <= '0;
        end else if (wr_en && has_ss) begin
            ss_q[slot] <= wr_data;
        end
    end

    assign rd_data = has_ss ? ss_q[slot] : '0;

    a_r9_user_status_zero: assert property (@(posedge clk) disable iff (rst)
        (mode == M_USR || mode == M_SYS) |-> rd_data == '0);

    a_r8_status_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && has_ss) |=> ($stable(mode) -> rd_data == $past(wr_data)));

endmodule

// File: rtl/mbreg_file.sv
module mbreg_file
    import mbreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode,
    input  logic [31:0]       pc_in,
    input  logic [3:0]        ra_idx,
    output logic [31:0]       ra_data,
    input  logic [3:0]        rb_idx,
    output logic [31:0]       rb_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              ss_wr_en,
    input  logic [31:0]       ss_wr_data,
    output logic [31:0]       ss_rd_data
);
    localparam int NRD = 2;

    logic [DATA_W-1:0] phys_q [PHYS_N];
    logic [IDX_W-1:0]  rd_idx [NRD];
    logic [DATA_W-1:0] rd_val [NRD];
    map_t              wr_map;

    assign rd_idx[0] = ra_idx;
    assign rd_idx[1] = rb_idx;

    mbreg_map u_wmap (.idx(wr_idx), .mode(mode), .map(wr_map));

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        map_t rmap;
        mbreg_map u_rmap (.idx(rd_idx[p]), .mode(mode), .map(rmap));
        assign rd_val[p] = rmap.is_pc ? pc_in : phys_q[rmap.phys];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_N; i++) phys_q[i] <= '0;
        end else if (wr_en && !wr_map.is_pc) begin
            phys_q[wr_map.phys] <= wr_data;
        end
    end

    assign ra_data = rd_val[0];
    assign rb_data = rd_val[1];

    mbreg_ss_bank u_ss (
        .clk(clk), .rst(rst), .mode(mode),
        .wr_en(ss_wr_en), .wr_data(ss_wr_data), .rd_data(ss_rd_data)
    );

    a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 4'hF) |=>
        ((ra_idx == $past(wr_idx) && $stable(mode)) -> ra_data == $past(wr_data)));

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ra_idx != 4'hF) |-> ra_data == '0);

    a_r4_pc_readback: assert property (@(posedge clk) disable iff (rst)
        (rb_idx == 4'hF) |-> rb_data == pc_in);

endmodule

// File: tb/mbreg_file_bench.sv
`timescale 1ns/1ps
module mbreg_file_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [4:0]  mode = 5'b10000;
    logic [31:0] pc_in = 32'hC0DE_0000;
    logic [3:0]  ra_idx = 0, rb_idx = 0, wr_idx = 0;
    logic [31:0] ra_data, rb_data, wr_data = 0, ss_wr_data = 0, ss_rd_data;
    logic        wr_en = 0, ss_wr_en = 0;

    int checks = 0, errors = 0;
    logic [4:0]  modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                               5'b10111, 5'b11011, 5'b11111};
    logic [31:0] mdl [7][15];
    logic [31:0] ssm [7];

    always #2.5 clk = ~clk;

    mbreg_file u_mbreg_file (
        .clk(clk), .rst(rst), .mode(mode), .pc_in(pc_in),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ss_wr_en(ss_wr_en), .ss_wr_data(ss_wr_data), .ss_rd_data(ss_rd_data)
    );

    // user (0) and system (6) form one group; fast interrupt is index 1
    function automatic bit same_grp(int a, int b);
        int ga = (a == 6) ? 0 : a;
        int gb = (b == 6) ? 0 : b;
        return ga == gb;
    endfunction

    function automatic bit shares(int a, int b, int r);
        if (r < 8) return 1;                    // R5
        if (r < 13) return (a == 1) == (b == 1); // R6
        return same_grp(a, b);                   // R7
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(int mi, int r, logic [31:0] d);
        @(negedge clk);
        mode = modes[mi]; wr_idx = 4'(r); wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        if (r < 15)
            for (int j = 0; j < 7; j++) if (shares(mi, j, r)) mdl[j][r] = d;
    endtask

    task automatic sweep(string req);
        for (int j = 0; j < 7; j++) begin
            for (int r = 0; r < 16; r++) begin
                mode = modes[j]; ra_idx = 4'(r); rb_idx = 4'(15 - r);
                #0.1;
                chk(req, ra_data, (r == 15) ? pc_in : mdl[j][r]);
                chk(req, rb_data, (r == 0) ? pc_in : mdl[j][15 - r]);
            end
            chk("R9", ss_rd_data, ssm[j]);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int j = 0; j < 7; j++) begin
            ssm[j] = 0;
            for (int r = 0; r < 15; r++) mdl[j][r] = 0;
        end
        repeat (3) @(posedge clk);
        // dirty write during reset must not survive
        wr_en = 1; wr_idx = 4'd3; wr_data = 32'hDEAD;
        @(negedge clk);
        rst = 0; wr_en = 0;
        sweep("R1");

        // R2 R5 R6 R7: every number in every mode, full cross-read
        for (int mi = 0; mi < 7; mi++)
            for (int r = 0; r < 15; r++) begin
                write_reg(mi, r, {8'hA5, 8'(mi), 8'(r), 8'h5A});
                pc_in = pc_in + 4;
                sweep("R2_R5_R6_R7");
            end

        // R4: write to number 15 in every mode changes nothing
        for (int mi = 0; mi < 7; mi++) write_reg(mi, 15, 32'hFFFF_0000 + mi);
        sweep("R4");

        // R3: same-cycle read during write returns old value
        @(negedge clk);
        mode = modes[3]; wr_idx = 4'd13; wr_data = 32'h1234_5678; wr_en = 1;
        ra_idx = 4'd13; rb_idx = 4'd13;
        #2.0;
        chk("R3", ra_data, mdl[3][13]);
        chk("R3", rb_data, mdl[3][13]);
        @(negedge clk);
        wr_en = 0; mdl[3][13] = 32'h1234_5678;
        #0.1;
        chk("R3", ra_data, 32'h1234_5678);

        // R10: unknown encoding behaves as user
        for (int k = 0; k < 2; k++) begin
            logic [4:0] bad = k ? 5'b00000 : 5'b10100;
            @(negedge clk);
            mode = bad; wr_idx = 4'd13; wr_data = 32'h0BAD_0000 + k; wr_en = 1;
            ss_wr_en = 1; ss_wr_data = 32'h7777;
            @(negedge clk);
            wr_en = 0; ss_wr_en = 0;
            mdl[0][13] = 32'h0BAD_0000 + k; mdl[6][13] = mdl[0][13];
            #0.1;
            chk("R10", ss_rd_data, 0);
            mode = modes[0]; #0.1;
            ra_idx = 4'd13; #0.1;
            chk("R10", ra_data, mdl[0][13]);
        end
        sweep("R10");

        // R8 R9: saved status per mode; user/system writes ignored
        for (int mi = 0; mi < 7; mi++) begin
            @(negedge clk);
            mode = modes[mi]; ss_wr_data = 32'h5500_0000 + mi; ss_wr_en = 1;
            #2.0;
            chk("R8", ss_rd_data, ssm[mi]);
            @(negedge clk);
            ss_wr_en = 0;
            if (mi != 0 && mi != 6) ssm[mi] = 32'h5500_0000 + mi;
            #0.1;
            chk("R8", ss_rd_data, ssm[mi]);
        end
        sweep("R8_R9");

        // R1: reset again clears all
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int j = 0; j < 7; j++) begin
            ssm[j] = 0;
            for (int r = 0; r < 15; r++) mdl[j][r] = 0;
        end
        sweep("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule